// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Entry Map

This block is the control unit of a 16-bit microcoded processor. A 256-word, 56-bit microcode store is addressed by an 8-bit microprogram counter. The word at the current microaddress is held in a pipeline register, and that register drives the datapath control lines. The sequencing fields of the held word pick the next microaddress. The next address is the following word, a branch target (always taken, or taken on a selected condition code), or a mapped entry point.

A 256-entry map memory turns an opcode byte into the first microaddress of that instruction's routine. The opcode byte comes either from the upper byte of the incoming data bus, during fetch, or from the instruction register, for a later dispatch. The instruction register captures the data bus when the current word asks for it. It presents the word as an opcode and two 4-bit register numbers.

Both memories are written through simple write ports, for example by a loader or a testbench. The block also brings out the microaddress and the sequencing fields for debug.

Top module: `useq`

## Requirements
- R1: While `rst` is high at a clock edge, the microaddress becomes 0, the pipeline register clears (so `ctrl`, `dbg_op`, `dbg_csel` and `dbg_baddr` are 0), and the instruction register clears.
- R2: On the first clock edge after reset is released, the microaddress stays at 0. The pipeline register then holds store word 0.
- R3: Sequencing op 0 (word bits 55:53) makes the next microaddress the current one plus 1, wrapping from 0xFF to 0x00.
- R4: Op 1 makes the next microaddress equal to the branch field (bits 49:42).
- R5: Op 2 takes the branch field when `cc_in[csel]` is 1 and otherwise advances by 1. The condition select csel is bits 52:50.
- R6: Op 3 takes the branch field when `cc_in[csel]` is 0 and otherwise advances by 1.
- R7: Op 4 makes the next microaddress the map entry indexed by `din[15:8]`.
- R8: Op 5 makes the next microaddress the map entry indexed by the instruction register's opcode byte.
- R9: When bit 41 of the held word is 1, the instruction register loads `din` at the clock edge. It shows bits 15:8 as `ir_op`, bits 7:4 as `ir_ra` and bits 3:0 as `ir_rb`. When bit 41 is 0 it holds its value.
- R10: After each edge, `ctrl` (word bits 40:0), `dbg_op`, `dbg_csel` and `dbg_baddr` show the store word at the new `dbg_upc`.
- R11: Op codes 6 and 7 advance the microaddress by 1, as op 0 does.
- R12: A write with `us_we` sets store word `us_waddr` to `us_wdata`. A write with `map_we` sets map entry `map_waddr` to `map_wdata`. Both take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_we | input | 1 | Microcode store write enable |
| us_waddr | input | 8 | Microcode store write address |
| us_wdata | input | 56 | Microcode store write data |
| map_we | input | 1 | Map memory write enable |
| map_waddr | input | 8 | Map memory write address (opcode) |
| map_wdata | input | 8 | Map entry value (microaddress) |
| din | input | 16 | Data bus from memory; the instruction word during fetch |
| cc_in | input | 8 | Condition codes, chosen by the condition select field |
| ctrl | output | 41 | Datapath control field of the held word |
| ir_op | output | 8 | Instruction register opcode byte |
| ir_ra | output | 4 | Instruction register first register number |
| ir_rb | output | 4 | Instruction register second register number |
| dbg_upc | output | 8 | Current microaddress |
| dbg_op | output | 3 | Sequencing op of the held word |
| dbg_csel | output | 3 | Condition select of the held word |
| dbg_baddr | output | 8 | Branch field of the held word |

## Verification
The bench drives all 256 opcodes through the data-bus dispatch. A design that takes the map index from the wrong byte, or that branches to the map index instead of the map entry, would land on the wrong microaddress. Sequential runs cross 0xFF, so a counter that saturates or does not wrap gets caught. Conditional branches are run under every select value with changing condition codes, which exposes a swapped polarity or a wrong select bit. The fetch sequence exposes a pipeline register that lags by one word, an instruction register that loads without its control bit, and an extra or missing stall cycle after reset.

// File: rtl/useq.sv
module useq #(
  parameter int AW  = 8,
  parameter int UW  = 56,
  parameter int DW  = 16,
  parameter int CCW = 8,
  parameter int OPW = 3,
  parameter int RW  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   us_we,
  input  logic [AW-1:0]                          us_waddr,
  input  logic [UW-1:0]                          us_wdata,
  input  logic                                   map_we,
  input  logic [AW-1:0]                          map_waddr,
  input  logic [AW-1:0]                          map_wdata,
  input  logic [DW-1:0]                          din,
  input  logic [CCW-1:0]                         cc_in,
  output logic [UW-OPW-$clog2(CCW)-AW-2:0]       ctrl,
  output logic [DW-2*RW-1:0]                     ir_op,
  output logic [RW-1:0]                          ir_ra,
  output logic [RW-1:0]                          ir_rb,
  output logic [AW-1:0]                          dbg_upc,
  output logic [OPW-1:0]                         dbg_op,
  output logic [$clog2(CCW)-1:0]                 dbg_csel,
  output logic [AW-1:0]                          dbg_baddr
);
  localparam int DEPTH = 1 << AW;
  localparam int CSW   = $clog2(CCW);
  localparam int OP_LO = UW - OPW;
  localparam int CS_LO = OP_LO - CSW;
  localparam int BA_LO = CS_LO - AW;
  localparam int IRLD  = BA_LO - 1;

  localparam logic [OPW-1:0] OP_JUMP = OPW'(1);
  localparam logic [OPW-1:0] OP_BRT  = OPW'(2);
  localparam logic [OPW-1:0] OP_BRF  = OPW'(3);
  localparam logic [OPW-1:0] OP_MAPD = OPW'(4);
  localparam logic [OPW-1:0] OP_MAPI = OPW'(5);

  logic [UW-1:0] ustore [DEPTH];
  logic [AW-1:0] umap   [DEPTH];
  logic [UW-1:0] pipe;
  logic [AW-1:0] upc, nxt;
  logic [DW-1:0] ir;
  logic          run;

  wire [OPW-1:0] op    = pipe[UW-1:OP_LO];
  wire [CSW-1:0] csel  = pipe[OP_LO-1:CS_LO];
  wire [AW-1:0]  badr  = pipe[CS_LO-1:BA_LO];
  wire           ir_ld = pipe[IRLD];
  wire           cond  = cc_in[csel];
  wire [AW-1:0]  inc   = upc + 1'b1;

  always_comb begin
    if (!run) nxt = '0;
    else begin
      case (op)
        OP_JUMP: nxt = badr;
        OP_BRT:  nxt = cond ? badr : inc;
        OP_BRF:  nxt = cond ? inc : badr;
        OP_MAPD: nxt = umap[din[DW-1 -: AW]];
        OP_MAPI: nxt = umap[ir[DW-1 -: AW]];
        default: nxt = inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (us_we)  ustore[us_waddr] <= us_wdata;
    if (map_we) umap[map_waddr]  <= map_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      upc  <= '0;
      pipe <= '0;
      ir   <= '0;
    end else begin
      run  <= 1'b1;
      upc  <= nxt;
      pipe <= ustore[nxt];
      if (ir_ld) ir <= din;
    end
  end

  assign ctrl      = pipe[IRLD-1:0];
  assign ir_op     = ir[DW-1:2*RW];
  assign ir_ra     = ir[2*RW-1:RW];
  assign ir_rb     = ir[RW-1:0];
  assign dbg_upc   = upc;
  assign dbg_op    = op;
  assign dbg_csel  = csel;
  assign dbg_baddr = badr;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int AW  = 8,
  parameter int CCW = 8,
  parameter int OPW = 3,
  parameter int IRW = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run,
  input logic                   ir_ld,
  input logic [AW-1:0]          upc,
  input logic [OPW-1:0]         op,
  input logic [$clog2(CCW)-1:0] csel,
  input logic [AW-1:0]          badr,
  input logic [CCW-1:0]         cc,
  input logic [IRW-1:0]         irv
);
  assert_first_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> upc == '0);

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    run && (op == OPW'(0) || op == OPW'(6) || op == OPW'(7)) |=> upc == AW'($past(upc) + 1'b1));

  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    run && op == OPW'(1) |=> upc == $past(badr));

  assert_brtrue_R5: assert property (@(posedge clk) disable iff (rst)
    run && op == OPW'(2) |=> upc == ($past(cc[csel]) ? $past(badr) : AW'($past(upc) + 1'b1)));

  assert_brfalse_R6: assert property (@(posedge clk) disable iff (rst)
    run && op == OPW'(3) |=> upc == ($past(cc[csel]) ? AW'($past(upc) + 1'b1) : $past(badr)));

  assert_ir_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ir_ld |=> $stable(irv));
endmodule

bind useq useq_chk #(.AW(AW), .CCW(CCW), .OPW(OPW), .IRW(DW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ir_ld(ir_ld), .upc(dbg_upc), .op(dbg_op),
  .csel(dbg_csel), .badr(dbg_baddr), .cc(cc_in), .irv({ir_op, ir_ra, ir_rb})
);

// File: tb/useq_tb.sv
`timescale 1ns/1ps
module useq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        us_we = 1'b0;
  logic [7:0]  us_waddr = '0;
  logic [55:0] us_wdata = '0;
  logic        map_we = 1'b0;
  logic [7:0]  map_waddr = '0;
  logic [7:0]  map_wdata = '0;
  logic [15:0] din = '0;
  logic [7:0]  cc_in = '0;
  logic [40:0] ctrl;
  logic [7:0]  ir_op;
  logic [3:0]  ir_ra, ir_rb;
  logic [7:0]  dbg_upc;
  logic [2:0]  dbg_op;
  logic [2:0]  dbg_csel;
  logic [7:0]  dbg_baddr;

  always #2.5 clk = ~clk;

  useq u_dut (
    .clk(clk), .rst(rst), .us_we(us_we), .us_waddr(us_waddr), .us_wdata(us_wdata),
    .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata), .din(din),
    .cc_in(cc_in), .ctrl(ctrl), .ir_op(ir_op), .ir_ra(ir_ra), .ir_rb(ir_rb),
    .dbg_upc(dbg_upc), .dbg_op(dbg_op), .dbg_csel(dbg_csel), .dbg_baddr(dbg_baddr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [55:0] bst  [256];
  logic [7:0]  bmap [256];
  logic [7:0]  exp_upc;
  logic [55:0] exp_pipe;
  logic [15:0] exp_ir;
  bit          first;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] mk(input logic [2:0] op, input logic [2:0] cs,
                                     input logic [7:0] ba, input logic ild, input logic [7:0] a);
    logic [7:0] m5;
    m5 = 8'(a * 5);
    return {op, cs, ba, ild, a[0], a, ~a, a ^ 8'hC3, 8'(a + 8'h17), m5};
  endfunction

  task automatic wr_us(input logic [7:0] a, input logic [55:0] w);
    us_we = 1'b1; us_waddr = a; us_wdata = w; bst[a] = w;
    @(posedge clk); #1;
    us_we = 1'b0;
  endtask

  task automatic wr_map(input logic [7:0] a, input logic [7:0] v);
    map_we = 1'b1; map_waddr = a; map_wdata = v; bmap[a] = v;
    @(posedge clk); #1;
    map_we = 1'b0;
  endtask

  task automatic go_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 upc", 64'(dbg_upc), 64'h0);
    chk("R1 fields", 64'({dbg_op, dbg_csel, dbg_baddr, ctrl}), 64'h0);
    chk("R1 ir", 64'({ir_op, ir_ra, ir_rb}), 64'h0);
    rst = 1'b0;
    exp_upc = 8'h00; exp_pipe = '0; exp_ir = '0; first = 1'b1;
  endtask

  task automatic tick(input logic [15:0] d, input logic [7:0] c);
    logic [7:0] nx, inc;
    logic [2:0] op, cs;
    logic [7:0] ba;
    string tag;
    din = d; cc_in = c;
    op = exp_pipe[55:53]; cs = exp_pipe[52:50]; ba = exp_pipe[49:42];
    inc = 8'(exp_upc + 8'd1);
    if (first) begin nx = 8'h00; tag = "R2"; end
    else begin
      case (op)
        3'd0: begin nx = inc; tag = "R3"; end
        3'd1: begin nx = ba; tag = "R4"; end
        3'd2: begin nx = c[cs] ? ba : inc; tag = "R5"; end
        3'd3: begin nx = c[cs] ? inc : ba; tag = "R6"; end
        3'd4: begin nx = bmap[d[15:8]]; tag = "R7"; end
        3'd5: begin nx = bmap[exp_ir[15:8]]; tag = "R8"; end
        default: begin nx = inc; tag = "R11"; end
      endcase
    end
    if (!first && exp_pipe[41]) exp_ir = d;
    exp_upc = nx; exp_pipe = bst[nx]; first = 1'b0;
    @(posedge clk); #1;
    chk(tag, 64'(dbg_upc), 64'(exp_upc));
    chk("R10/R12 fields", 64'({dbg_op, dbg_csel, dbg_baddr, ctrl}),
        64'({exp_pipe[55:42], exp_pipe[40:0]}));
    chk("R9 ir", 64'({ir_op, ir_ra, ir_rb}), 64'(exp_ir));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // map: opcode o -> o ^ 0x44 (0x2B -> 0x6F)
    for (int o = 0; o < 256; o++) wr_map(8'(o), 8'(o) ^ 8'h44);

    // Phase A: data-bus dispatch over every opcode (R7, R12, R4)
    for (int a = 0; a < 256; a++)
      wr_us(8'(a), (a == 0) ? mk(3'd4, 3'd0, 8'h00, 1'b0, 8'(a)) : mk(3'd1, 3'd0, 8'h00, 1'b0, 8'(a)));
    go_reset();
    tick(16'h0000, 8'h00);
    for (int o = 0; o < 256; o++) begin
      tick({8'(o), 8'(o)}, 8'h00);
      tick({8'(o), 8'(o)}, 8'h00);
    end

    // Phase B: sequential with wrap, ops 6 and 7 (R3, R11)
    rst = 1'b1;
    for (int a = 0; a < 256; a++)
      wr_us(8'(a), mk((a % 7 == 3) ? 3'd6 : (a % 11 == 5) ? 3'd7 : 3'd0, 3'(a), 8'(a + 9), 1'b0, 8'(a)));
    go_reset();
    for (int i = 0; i < 300; i++) tick(16'(i * 13), 8'(i));

    // Phase C: conditional branches over all selects (R5, R6)
    rst = 1'b1;
    for (int a = 0; a < 256; a++)
      wr_us(8'(a), mk(a[0] ? 3'd3 : 3'd2, 3'(a >> 1), 8'(a * 37 + 11), 1'b0, 8'(a)));
    go_reset();
    for (int i = 0; i < 600; i++) tick(16'h0, 8'(i * 29 + 7) ^ 8'(i >> 3));

    // Phase D: fetch, instruction register, IR dispatch (R7, R8, R9)
    rst = 1'b1;
    for (int a = 0; a < 256; a++) begin
      logic [55:0] w;
      if (a < 4)          w = mk(3'd0, 3'd0, 8'h00, 1'b0, 8'(a));
      else if (a == 4)    w = mk(3'd4, 3'd0, 8'h00, 1'b1, 8'(a));
      else if (a == 8'h6F) w = mk(3'd3, 3'd0, 8'h90, 1'b0, 8'(a));
      else if (a == 8'h90) w = mk(3'd5, 3'd0, 8'h00, 1'b0, 8'(a));
      else if (a == 8'h70) w = mk(3'd1, 3'd0, 8'h00, 1'b1, 8'(a));
      else                w = mk(3'd1, 3'd0, 8'h00, 1'b0, 8'(a));
      wr_us(8'(a), w);
    end
    go_reset();
    for (int i = 0; i < 6; i++) tick(16'h2B34, 8'h00);
    chk("R7 fetch entry 0x6F", 64'(dbg_upc), 64'h6F);
    chk("R9 ir split 2B/3/4", 64'({ir_op, ir_ra, ir_rb}), 64'h2B34);
    for (int i = 0; i < 400; i++) tick(16'(16'h2B34 + (i / 6) * 16'h3B1D), 8'((i / 3) & 1));

    finish_run();
  end
endmodule